// File: doc/BRIEF.md
# Pipelined Single-Precision Multiplier with Exception Flags

This block multiplies two 32-bit IEEE-754 binary32 operands and returns a 32-bit result word together with six exception flags. Its datapath is fully pipelined: a new operand pair may be presented on every clock cycle. Each accepted pair yields exactly one result a fixed number of cycles later. Special operands (NaN, infinity, zero) are recognised early and bypass the arithmetic path. Finite operands go through sign combination, exponent addition with bias removal, a 24x24-bit significand product, a one-bit normalisation step and round-to-nearest-even.

The interface is a plain valid strobe on each side with no ready signal. The block never applies back-pressure and cannot be stalled, so the consumer must be able to take one result in every cycle in which `out_valid` is high. Operands whose exponent field is zero are treated as zero, and subnormal results are never produced. A product whose exponent leaves the normal range is replaced by a signalling-NaN marker, and a flag names the direction of the range error.

Top module: `fpmul_pipe`

## Requirements
- R1: If either operand is a NaN (exponent field all ones, fraction non-zero), the result is 0x7FC00000 and only the QNaN flag is set.
- R2: An operand with a zero exponent field counts as zero. Zero times zero or times a finite value, of either sign, gives 0x00000000 with every flag clear.
- R3: Zero times an infinity, in either operand order, gives 0x7FC00000 with only the QNaN flag set.
- R4: An infinity times a finite non-zero value or an infinity gives an infinity whose sign is the XOR of the operand signs. The result is 0x7F800000 with PINF set, or 0xFF800000 with NINF set.
- R5: For finite non-zero operands, the sign is the XOR of the operand signs and the exponent is the sum of the operand exponents minus 127, plus one when the significand product is 2.0 or more. For example, 0x1EC7A735 times 0x6ECF15E8 gives 0x4E21814A.
- R6: Finite products are rounded to nearest with ties to even. A rounding carry out of the fraction increments the exponent.
- R7: If the final biased exponent is 255 or more, the result is 0x7FA00000 with the overflow and SNaN flags set.
- R8: If the final biased exponent is 0 or less, the result is 0x7FA00000 with the underflow and SNaN flags set.
- R9: `out_valid` rises for exactly one cycle, 14 cycles after the cycle in which `in_valid` was sampled high. Operand pairs offered in consecutive cycles emerge in consecutive cycles, in order.
- R10: While `out_valid` is low, all six flags are low.
- R11: Reset clears every stage, so a result that is in flight when reset is asserted never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register samples on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair on op_a/op_b is taken in this cycle |
| op_a | input | 32 | First binary32 operand |
| op_b | input | 32 | Second binary32 operand |
| out_valid | output | 1 | result and flags belong to an accepted pair |
| result | output | 32 | Product word or special encoding |
| flg_ovf | output | 1 | Exponent overflow |
| flg_unf | output | 1 | Exponent underflow |
| flg_qnan | output | 1 | Invalid operation or NaN operand; quiet NaN returned |
| flg_snan | output | 1 | Range error; signalling NaN marker returned |
| flg_pinf | output | 1 | Result is positive infinity |
| flg_ninf | output | 1 | Result is negative infinity |

## Verification
A fault in a stage register, or a miscounted delay line, shows up as `out_valid` arriving one cycle early or late. It can also show up as a lost or doubled pulse, which becomes visible exactly at the 14th cycle after the input strobe. A wrong decision in the rounding or normalisation logic appears at that same cycle as a result word off by one unit in the last place, or as a mantissa/exponent pair shifted by one. A fault in the special-case decode appears there too, as a NaN or infinity word paired with the wrong flag. Back-to-back streams expose any stage that holds a value over from the previous operand pair.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;
  localparam int EXT_W  = EXP_W + 2;
  localparam int BIAS   = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  localparam logic [WORD_W-1:0] QNAN_WORD = {1'b0, {EXP_W{1'b1}}, 2'b10, {(FRAC_W-2){1'b0}}};
  localparam logic [WORD_W-1:0] SNAN_WORD = {1'b0, {EXP_W{1'b1}}, 2'b01, {(FRAC_W-2){1'b0}}};

  typedef enum logic [1:0] {OPK_FIN, OPK_ZERO, OPK_INF, OPK_NAN} opkind_e;

  typedef struct packed {
    logic ovf;
    logic unf;
    logic qnan;
    logic snan;
    logic pinf;
    logic ninf;
  } fpm_flags_t;

  localparam int FLAG_W = $bits(fpm_flags_t);
endpackage

// File: rtl/fpm_classify.sv
`timescale 1ns/1ps
module fpm_classify
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output opkind_e           kind
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  always_comb begin
    exp_f  = word[WORD_W-2:FRAC_W];
    frac_f = word[FRAC_W-1:0];
    if (exp_f == '0)
      kind = OPK_ZERO;
    else if (exp_f == {EXP_W{1'b1}})
      kind = (frac_f == '0) ? OPK_INF : OPK_NAN;
    else
      kind = OPK_FIN;
  end
endmodule

// File: rtl/fpm_round.sv
`timescale 1ns/1ps
module fpm_round
  import fpm_pkg::*;
(
  input  logic                    sign,
  input  logic signed [EXT_W-1:0] esum,
  input  logic [PROD_W-1:0]       prod,
  output logic [WORD_W-1:0]       word,
  output fpm_flags_t              flags
);
  localparam logic signed [EXT_W-1:0] E_TOP = EXT_W'(EXP_MAX);

  logic                    hi;
  logic [PROD_W-1:0]       norm;
  logic [FRAC_W-1:0]       frac;
  logic                    guard, sticky, rnd;
  logic [FRAC_W:0]         sum;
  logic signed [EXT_W-1:0] e_fin;

  always_comb begin
    hi     = prod[PROD_W-1];
    norm   = hi ? prod : (prod << 1);
    frac   = norm[PROD_W-2 -: FRAC_W];
    guard  = norm[PROD_W-2-FRAC_W];
    sticky = |norm[PROD_W-3-FRAC_W:0];
    rnd    = guard & (sticky | frac[0]);
    sum    = {1'b0, frac} + {{FRAC_W{1'b0}}, rnd};
    e_fin  = esum + $signed({{(EXT_W-1){1'b0}}, hi})
                  + $signed({{(EXT_W-1){1'b0}}, sum[FRAC_W]});
    flags  = '0;
    if (e_fin >= E_TOP) begin
      word       = SNAN_WORD;
      flags.ovf  = 1'b1;
      flags.snan = 1'b1;
    end else if (e_fin <= 0) begin
      word       = SNAN_WORD;
      flags.unf  = 1'b1;
      flags.snan = 1'b1;
    end else begin
      word = {sign, e_fin[EXP_W-1:0], sum[FRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/fpm_delay.sv
`timescale 1ns/1ps
module fpm_delay #(
  parameter int W = 8,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (D == 0) begin : g_pass
      assign q = d;
    end else begin : g_line
      logic [W-1:0] taps [D];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < D; i++) taps[i] <= '0;
        end else begin
          taps[0] <= d;
          for (int i = 1; i < D; i++) taps[i] <= taps[i-1];
        end
      end
      assign q = taps[D-1];
    end
  endgenerate
endmodule

// File: rtl/fpmul_pipe.sv
`timescale 1ns/1ps
module fpmul_pipe
  import fpm_pkg::*;
#(
  parameter int LATENCY = 14
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flg_ovf,
  output logic        flg_unf,
  output logic        flg_qnan,
  output logic        flg_snan,
  output logic        flg_pinf,
  output logic        flg_ninf
);
  localparam int CORE_STAGES = 3;
  localparam int TAIL        = LATENCY - CORE_STAGES;
  localparam int BUS_W       = 1 + WORD_W + FLAG_W;

  // stage 0: operand decode (combinational)
  opkind_e                 ka, kb;
  logic signed [EXT_W-1:0] esum0;

  fpm_classify u_cls_a (.word(op_a), .kind(ka));
  fpm_classify u_cls_b (.word(op_b), .kind(kb));

  assign esum0 = $signed({2'b00, op_a[WORD_W-2:FRAC_W]})
               + $signed({2'b00, op_b[WORD_W-2:FRAC_W]})
               - $signed(EXT_W'(BIAS));

  // stage 1 registers
  logic                    s1_v, s1_sign;
  opkind_e                 s1_ka, s1_kb;
  logic signed [EXT_W-1:0] s1_esum;
  logic [SIG_W-1:0]        s1_ma, s1_mb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s1_sign <= 1'b0;
      s1_ka <= OPK_ZERO; s1_kb <= OPK_ZERO;
      s1_esum <= '0; s1_ma <= '0; s1_mb <= '0;
    end else begin
      s1_v    <= in_valid;
      s1_sign <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
      s1_ka   <= ka;
      s1_kb   <= kb;
      s1_esum <= esum0;
      s1_ma   <= {1'b1, op_a[FRAC_W-1:0]};
      s1_mb   <= {1'b1, op_b[FRAC_W-1:0]};
    end
  end

  // special-case decision, in parallel with the significand product
  logic              spec1;
  logic [WORD_W-1:0] sword1;
  fpm_flags_t        sflags1;

  always_comb begin
    spec1   = 1'b1;
    sword1  = '0;
    sflags1 = '0;
    if (s1_ka == OPK_NAN || s1_kb == OPK_NAN) begin
      sword1 = QNAN_WORD; sflags1.qnan = 1'b1;
    end else if ((s1_ka == OPK_ZERO && s1_kb == OPK_INF) ||
                 (s1_ka == OPK_INF && s1_kb == OPK_ZERO)) begin
      sword1 = QNAN_WORD; sflags1.qnan = 1'b1;
    end else if (s1_ka == OPK_INF || s1_kb == OPK_INF) begin
      sword1 = {s1_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      sflags1.pinf = !s1_sign;
      sflags1.ninf = s1_sign;
    end else if (s1_ka == OPK_ZERO || s1_kb == OPK_ZERO) begin
      sword1 = '0;
    end else begin
      spec1 = 1'b0;
    end
  end

  // stage 2 registers
  logic                    s2_v, s2_sign, s2_spec;
  logic signed [EXT_W-1:0] s2_esum;
  logic [PROD_W-1:0]       s2_prod;
  logic [WORD_W-1:0]       s2_sword;
  fpm_flags_t              s2_sflags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v <= 1'b0; s2_sign <= 1'b0; s2_spec <= 1'b0;
      s2_esum <= '0; s2_prod <= '0; s2_sword <= '0; s2_sflags <= '0;
    end else begin
      s2_v      <= s1_v;
      s2_sign   <= s1_sign;
      s2_spec   <= spec1;
      s2_esum   <= s1_esum;
      s2_prod   <= s1_ma * s1_mb;
      s2_sword  <= sword1;
      s2_sflags <= sflags1;
    end
  end

  // normalise, round, range check
  logic [WORD_W-1:0] rword;
  fpm_flags_t        rflags;

  fpm_round u_round (
    .sign (s2_sign),
    .esum (s2_esum),
    .prod (s2_prod),
    .word (rword),
    .flags(rflags)
  );

  // stage 3 registers, qualified by valid
  logic              s3_v;
  logic [WORD_W-1:0] s3_word;
  fpm_flags_t        s3_flags;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s3_v <= 1'b0; s3_word <= '0; s3_flags <= '0;
    end else begin
      s3_v     <= s2_v;
      s3_word  <= !s2_v ? '0 : (s2_spec ? s2_sword : rword);
      s3_flags <= !s2_v ? '0 : (s2_spec ? s2_sflags : rflags);
    end
  end

  // latency padding
  logic [BUS_W-1:0] tail_q;
  fpm_flags_t       out_flags;

  fpm_delay #(.W(BUS_W), .D(TAIL)) u_tail (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({s3_v, s3_word, s3_flags}),
    .q    (tail_q)
  );

  assign out_valid = tail_q[BUS_W-1];
  assign result    = tail_q[BUS_W-2 -: WORD_W];
  assign out_flags = fpm_flags_t'(tail_q[FLAG_W-1:0]);
  assign flg_ovf   = out_flags.ovf;
  assign flg_unf   = out_flags.unf;
  assign flg_qnan  = out_flags.qnan;
  assign flg_snan  = out_flags.snan;
  assign flg_pinf  = out_flags.pinf;
  assign flg_ninf  = out_flags.ninf;
endmodule

// File: rtl/fpm_check.sv
`timescale 1ns/1ps
module fpm_check
  import fpm_pkg::*;
#(
  parameter int LATENCY = 14
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        flg_ovf,
  input logic        flg_unf,
  input logic        flg_qnan,
  input logic        flg_snan,
  input logic        flg_pinf,
  input logic        flg_ninf
);
  logic [LATENCY-1:0] vq, nanq, zq;
  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;

  always_comb begin
    a_zero = op_a[30:23] == 8'h00;
    b_zero = op_b[30:23] == 8'h00;
    a_inf  = op_a[30:0] == 31'h7F800000;
    b_inf  = op_b[30:0] == 31'h7F800000;
    a_nan  = op_a[30:23] == 8'hFF && !a_inf;
    b_nan  = op_b[30:23] == 8'hFF && !b_inf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vq <= '0; nanq <= '0; zq <= '0;
    end else begin
      vq   <= {vq[LATENCY-2:0], in_valid};
      nanq <= {nanq[LATENCY-2:0], a_nan | b_nan};
      zq   <= {zq[LATENCY-2:0],
               (a_zero | b_zero) & !a_nan & !b_nan & !a_inf & !b_inf};
    end
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vq[LATENCY-1] == out_valid);

  p_nan_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && nanq[LATENCY-1]) |-> (flg_qnan && result == QNAN_WORD && !flg_snan));

  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && zq[LATENCY-1]) |->
      (result == 32'h0 && !flg_ovf && !flg_unf && !flg_qnan && !flg_snan && !flg_pinf && !flg_ninf));

  p_qnan_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flg_qnan |-> (result == QNAN_WORD));

  p_inf_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flg_pinf |-> result == 32'h7F800000) and (flg_ninf |-> result == 32'hFF800000));

  p_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flg_ovf |-> (flg_snan && !flg_unf && result == SNAN_WORD));

  p_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flg_unf |-> (flg_snan && !flg_ovf && result == SNAN_WORD));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(flg_ovf | flg_unf | flg_qnan | flg_snan | flg_pinf | flg_ninf));

  p_one_kind_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flg_qnan, flg_snan, flg_pinf, flg_ninf}));
endmodule

bind fpmul_pipe fpm_check #(.LATENCY(LATENCY)) u_fpm_check (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .out_valid(out_valid), .result(result), .flg_ovf(flg_ovf), .flg_unf(flg_unf),
  .flg_qnan(flg_qnan), .flg_snan(flg_snan), .flg_pinf(flg_pinf), .flg_ninf(flg_ninf)
);

// File: tb/fpmul_pipe_test.sv
`timescale 1ns/1ps
module fpmul_pipe_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        flg_ovf, flg_unf, flg_qnan, flg_snan, flg_pinf, flg_ninf;
  logic [5:0]  fl;

  int n_chk = 0;
  int n_bad = 0;

  // flag vector order: {ovf, unf, qnan, snan, pinf, ninf}
  localparam logic [5:0] F_NONE = 6'b000000;
  localparam logic [5:0] F_OVF  = 6'b100100;
  localparam logic [5:0] F_UNF  = 6'b010100;
  localparam logic [5:0] F_QNAN = 6'b001000;
  localparam logic [5:0] F_PINF = 6'b000010;
  localparam logic [5:0] F_NINF = 6'b000001;

  always #4 clk = ~clk;

  assign fl = {flg_ovf, flg_unf, flg_qnan, flg_snan, flg_pinf, flg_ninf};

  fpmul_pipe uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result), .flg_ovf(flg_ovf), .flg_unf(flg_unf),
    .flg_qnan(flg_qnan), .flg_snan(flg_snan), .flg_pinf(flg_pinf), .flg_ninf(flg_ninf)
  );

  task automatic check(input logic ok, input string req, input logic [38:0] act, input logic [38:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_out(input logic [31:0] ew, input logic [5:0] ef, input string req);
    check(out_valid === 1'b1 && result === ew && fl === ef, req,
          {out_valid, result, fl}, {1'b1, ew, ef});
  endtask

  // one operand pair, checked at 13, 14 and 15 cycles (R9)
  task automatic run_one(input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] ew, input logic [5:0] ef, input string req);
    @(negedge clk); op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0 && fl === F_NONE, "R9 early/R10", {out_valid, 32'h0, fl}, 39'h0);
    @(negedge clk);
    check_out(ew, ef, req);
    @(negedge clk);
    check(out_valid === 1'b0 && fl === F_NONE, "R9 pulse/R10", {out_valid, 32'h0, fl}, 39'h0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && result === 32'h0 && fl === F_NONE, "R11 reset state",
          {out_valid, result, fl}, 39'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_finite;
    run_one(32'h1EC7A735, 32'h6ECF15E8, 32'h4E21814A, F_NONE, "R5 example");
    run_one(32'h3FC00000, 32'h40000000, 32'h40400000, F_NONE, "R5 1.5*2");
    run_one(32'hBFC00000, 32'h40000000, 32'hC0400000, F_NONE, "R5 sign xor");
    run_one(32'h3FC00000, 32'h3FC00000, 32'h40100000, F_NONE, "R5 product>=2 normalise");
  endtask

  task automatic t_round;
    run_one(32'h3F800800, 32'h3F800800, 32'h3F801000, F_NONE, "R6 tie to even stays");
    run_one(32'h3FC00000, 32'h3F800001, 32'h3FC00002, F_NONE, "R6 tie to even rounds up");
    run_one(32'h3F800800, 32'h3F800801, 32'h3F801002, F_NONE, "R6 above half");
    run_one(32'h3F800001, 32'h3FFFFFFE, 32'h40000000, F_NONE, "R6 carry into exponent");
  endtask

  task automatic t_nan;
    run_one(32'h7FC00000, 32'h7F800000, 32'h7FC00000, F_QNAN, "R1 qnan operand");
    run_one(32'h3F800000, 32'hFF800001, 32'h7FC00000, F_QNAN, "R1 snan operand");
  endtask

  task automatic t_zero;
    run_one(32'h80000000, 32'hC0000000, 32'h00000000, F_NONE, "R2 neg zero * neg finite");
    run_one(32'h00000001, 32'h3F800000, 32'h00000000, F_NONE, "R2 zero exponent field");
    run_one(32'h00000000, 32'h80000000, 32'h00000000, F_NONE, "R2 zero * zero");
    run_one(32'h00000000, 32'hFF800000, 32'h7FC00000, F_QNAN, "R3 zero * -inf");
    run_one(32'h7F800000, 32'h80000000, 32'h7FC00000, F_QNAN, "R3 inf * zero");
  endtask

  task automatic t_inf;
    run_one(32'h7F800000, 32'hBF800000, 32'hFF800000, F_NINF, "R4 inf * neg");
    run_one(32'hFF800000, 32'hFF800000, 32'h7F800000, F_PINF, "R4 -inf * -inf");
    run_one(32'h40000000, 32'h7F800000, 32'h7F800000, F_PINF, "R4 finite * inf");
  endtask

  task automatic t_range;
    run_one(32'h7F000000, 32'h7F000000, 32'h7FA00000, F_OVF, "R7 overflow");
    run_one(32'h7F7FFFFF, 32'h3F800001, 32'h7FA00000, F_OVF, "R7 overflow via rounding");
    run_one(32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, F_NONE, "R7 largest finite kept");
    run_one(32'h00800000, 32'h00800000, 32'h7FA00000, F_UNF, "R8 underflow");
    run_one(32'hBF800000, 32'h00800000, 32'h80800000, F_NONE, "R8 smallest normal kept");
  endtask

  task automatic t_stream;
    @(negedge clk); op_a = 32'h3FC00000; op_b = 32'h3FC00000; in_valid = 1'b1;
    @(negedge clk); op_a = 32'h3FC00000; op_b = 32'h40000000;
    @(negedge clk); op_a = 32'h7F800000; op_b = 32'hBF800000;
    @(negedge clk); in_valid = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check(out_valid === 1'b0, "R9 stream early", {38'h0, out_valid}, 39'h0);
    @(negedge clk); check_out(32'h40100000, F_NONE, "R9 stream first");
    @(negedge clk); check_out(32'h40400000, F_NONE, "R9 stream second");
    @(negedge clk); check_out(32'hFF800000, F_NINF, "R9 stream third");
    @(negedge clk);
    check(out_valid === 1'b0 && fl === F_NONE, "R9 stream end/R10", {out_valid, 32'h0, fl}, 39'h0);
  endtask

  task automatic t_flush;
    logic seen;
    seen = 1'b0;
    @(negedge clk); op_a = 32'h3FC00000; op_b = 32'h40000000; in_valid = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (out_valid !== 1'b0) seen = 1'b1;
    end
    check(!seen, "R11 in-flight result discarded", {38'h0, seen}, 39'h0);
  endtask

  initial begin
    t_reset;
    t_finite;
    t_round;
    t_nan;
    t_zero;
    t_inf;
    t_range;
    t_stream;
    t_flush;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule